// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the 32-bit program counter of a simple load-store processor and picks the following fetch address every cycle. It looks at the instruction currently being executed and at the two register operand values that were read for it. From these it chooses between straight-line flow, a PC-relative conditional branch on operand equality or inequality, a region-preserving absolute jump, a jump that also records a return address, and a jump to an address held in a register.

The surrounding pipeline or sequencer presents one instruction word and its operand values at a time, and raises the advance input when that instruction is to be retired. The unit updates its PC only on such cycles. When the instruction is a call, the unit also raises a link write request in the same cycle, carrying the return address and the destination register number, so the register file can capture it at that edge. Fetch memory, the register file and exceptions lie outside the block.

Instruction fields the block decodes: opcode in bits 31:26, function code in bits 5:0, branch offset in bits 15:0, jump word address in bits 25:0.

Top module: `pcu_next_addr`

## Requirements
- R1: With rst_n low at a rising clock edge the PC becomes 0x00000000, whatever the advance input and instruction are.
- R2: With adv low at a rising edge the PC keeps its value, whatever instruction is presented.
- R3: With adv high, any instruction that is not one of the five transfers in R4 to R8 (for example opcode 8, or opcode 0 with a function code other than 8) loads PC+4, wrapping modulo 2^32.
- R4: Opcode 4 (branch-if-equal) loads (PC+4) + (sign-extended bits 15:0 shifted left by two) when both operand values are equal, and PC+4 otherwise.
- R5: Opcode 5 (branch-if-different) loads the same PC-relative target when the operand values differ, and PC+4 otherwise; at PC 80012 with offset 2 it reaches 80024.
- R6: Opcode 2 (jump) loads {bits 31:28 of PC+4, bits 25:0 of the instruction, 2'b00}; word field 20000 from the lowest 256 MB region gives 80000.
- R7: Opcode 3 (jump-and-link) loads the same target as R6.
- R8: Opcode 0 with function code 8 (jump-register) loads the rs operand value unchanged.
- R9: link_we is high exactly during a cycle with adv high and opcode 3; link_addr is always 31 and link_data always equals the current PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| adv | input | 1 | Retire the presented instruction and update the PC |
| instr | input | 32 | Instruction word being executed |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write request |
| link_addr | output | 5 | Destination register of the return address |
| link_data | output | 32 | Return address, PC+4 |

## Verification
A fault in the PC register or next-address selection shows on the pc port one edge after the advancing instruction, and because every later address is built on it, the error persists into all following vectors rather than healing. A wrong branch decision or a wrong offset scaling appears as a target off by four or by a multiple of four; a wrong region source for jumps appears only when the PC sits in a nonzero 256 MB region, which the vectors deliberately reach. A wrong link decision shows combinationally on link_we in the very cycle the call is presented, before any edge.

// File: rtl/pcu_pkg.sv
// pcu_pkg: shared widths, opcode values and the transfer-kind type
// for the next-address unit. Assumes a 32-bit, word-aligned program.
package pcu_pkg;

    localparam int XLEN      = 32;
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int OFS_W     = 16;
    localparam int JFIELD_W  = 26;
    localparam int REG_IDX_W = 5;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OPC_CALL    = 6'd3;
    localparam logic [OP_W-1:0] OPC_BR_EQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BR_NE   = 6'd5;
    localparam logic [FN_W-1:0] FN_JREG     = 6'd8;

    typedef enum logic [2:0] {
        XFER_SEQ,
        XFER_BEQ,
        XFER_BNE,
        XFER_JMP,
        XFER_CALL,
        XFER_JREG
    } xfer_e;

endpackage

// File: rtl/pcu_decode.sv
// pcu_decode: classifies an instruction into one transfer kind.
// Assumes opcode and function code are already split out by the caller;
// any encoding not recognised is treated as straight-line flow.
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output xfer_e           kind
);

    // Map opcode/function pair to a transfer kind.
    always_comb begin
        unique case (opcode)
            OPC_JUMP:    kind = XFER_JMP;
            OPC_CALL:    kind = XFER_CALL;
            OPC_BR_EQ:   kind = XFER_BEQ;
            OPC_BR_NE:   kind = XFER_BNE;
            OPC_SPECIAL: kind = (funct == FN_JREG) ? XFER_JREG : XFER_SEQ;
            default:     kind = XFER_SEQ;
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
// pcu_target: computes PC+4, the PC-relative branch target, the
// region-preserving jump target, and selects the next PC by kind.
// Assumes operands are compared as raw bit patterns for equality.
module pcu_target
    import pcu_pkg::*;
#(
    parameter int REGION_BITS = 4
) (
    input  logic [XLEN-1:0]     pc_cur,
    input  xfer_e               kind,
    input  logic [JFIELD_W-1:0] field,
    input  logic [XLEN-1:0]     rs_val,
    input  logic [XLEN-1:0]     rt_val,
    output logic [XLEN-1:0]     pc_plus4,
    output logic [XLEN-1:0]     pc_next
);

    localparam int SEXT_W = XLEN - OFS_W - 2;

    logic [XLEN-1:0] br_dest;
    logic [XLEN-1:0] jmp_dest;
    logic            ops_equal;
    logic            take_branch;

    // Sequential address and operand comparison.
    always_comb begin
        pc_plus4  = pc_cur + XLEN'(4);
        ops_equal = (rs_val == rt_val);
    end

    // Word offset, sign-extended and scaled, added to PC+4.
    always_comb begin
        br_dest = pc_plus4 +
            {{SEXT_W{field[OFS_W-1]}}, field[OFS_W-1:0], 2'b00};
    end

    // Absolute jump keeps the region bits of PC+4.
    generate
        if (REGION_BITS > 0) begin : g_region
            always_comb jmp_dest = {pc_plus4[XLEN-1 -: REGION_BITS], field, 2'b00};
        end else begin : g_flat
            always_comb jmp_dest = XLEN'({field, 2'b00});
        end
    endgenerate

    // Branch decision per conditional kind.
    always_comb begin
        unique case (kind)
            XFER_BEQ: take_branch = ops_equal;
            XFER_BNE: take_branch = !ops_equal;
            default:  take_branch = 1'b0;
        endcase
    end

    // Final next-address selection.
    always_comb begin
        unique case (kind)
            XFER_JMP, XFER_CALL: pc_next = jmp_dest;
            XFER_JREG:           pc_next = rs_val;
            XFER_BEQ, XFER_BNE:  pc_next = take_branch ? br_dest : pc_plus4;
            default:             pc_next = pc_plus4;
        endcase
    end

endmodule

// File: rtl/pcu_pc_reg.sv
// pcu_pc_reg: the program counter register with synchronous active-low
// reset and an advance enable. Reset wins over advance.
module pcu_pc_reg
    import pcu_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_q
);

    // Load reset address, or the next PC when advancing.
    always_ff @(posedge clk) begin
        if (!rst_n)   pc_q <= RESET_ADDR;
        else if (adv) pc_q <= pc_next;
    end

    AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pc_q)); // R2

endmodule

// File: rtl/pcu_next_addr.sv
// pcu_next_addr: top of the next-address unit. Decodes the presented
// instruction, computes the following PC, holds it, and raises a
// return-address write request for calls. Assumes the caller keeps
// instr and operands stable around the clock edge.
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int LINK_REG    = 31,
    parameter int REGION_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [XLEN-1:0]      instr,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    output logic [XLEN-1:0]      pc,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_addr,
    output logic [XLEN-1:0]      link_data
);

    xfer_e           kind;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_next;

    pcu_decode u_dec (
        .opcode (instr[XLEN-1 -: OP_W]),
        .funct  (instr[FN_W-1:0]),
        .kind   (kind)
    );

    pcu_target #(.REGION_BITS(REGION_BITS)) u_tgt (
        .pc_cur   (pc),
        .kind     (kind),
        .field    (instr[JFIELD_W-1:0]),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .pc_plus4 (pc_plus4),
        .pc_next  (pc_next)
    );

    pcu_pc_reg u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .pc_next (pc_next),
        .pc_q    (pc)
    );

    // Return-address request, valid only while a call retires.
    always_comb begin
        link_we   = adv && (kind == XFER_CALL);
        link_addr = REG_IDX_W'(LINK_REG);
        link_data = pc_plus4;
    end

    AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (adv && instr[XLEN-1 -: OP_W] == OPC_CALL)); // R9
    AST_LINK_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == pc + XLEN'(4) && link_addr == 5'd31)); // R9
    AST_JREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && kind == XFER_JREG) |=> pc == $past(rs_val)); // R8
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && kind == XFER_SEQ) |=> pc == $past(pc) + XLEN'(4)); // R3
    AST_BEQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && kind == XFER_BEQ && rs_val != rt_val) |=> pc == $past(pc) + XLEN'(4)); // R4
    AST_BNE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && kind == XFER_BNE && rs_val == rt_val) |=> pc == $past(pc) + XLEN'(4)); // R5
    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (kind == XFER_JMP || kind == XFER_CALL))
        |=> (pc[XLEN-1 -: 4] == $past(pc_plus4[XLEN-1 -: 4]) && pc[1:0] == 2'b00)); // R6

endmodule

// File: tb/sim_pcu_next_addr.sv
module sim_pcu_next_addr;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [31:0] pc_exp;
        logic        lwe_exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h00000000, 32'd0,        32'd0, 32'd4,        1'b0}, // R3 nop
        '{32'h20000005, 32'd0,        32'd0, 32'd8,        1'b0}, // R3 opcode 8
        '{32'h02328020, 32'd0,        32'd0, 32'd12,       1'b0}, // R3 funct 32
        '{32'h08004E23, 32'd0,        32'd0, 32'd80012,    1'b0}, // R6
        '{32'h14000002, 32'd1,        32'd2, 32'd80024,    1'b0}, // R5 taken
        '{32'h14000002, 32'd7,        32'd7, 32'd80028,    1'b0}, // R5 not taken
        '{32'h1000FFFF, 32'd3,        32'd3, 32'd80028,    1'b0}, // R4 taken, -1
        '{32'h10000005, 32'd1,        32'd0, 32'd80032,    1'b0}, // R4 not taken
        '{32'h0C004E20, 32'd0,        32'd0, 32'd80000,    1'b1}, // R7
        '{32'h01200008, 32'h1000,     32'd0, 32'h1000,     1'b0}, // R8
        '{32'h10008000, 32'd5,        32'd5, 32'hFFFE1004, 1'b0}, // R4 min offset
        '{32'h08000000, 32'd0,        32'd0, 32'hF0000000, 1'b0}, // R6 upper region
        '{32'h01200008, 32'hFFFFFFFC, 32'd0, 32'hFFFFFFFC, 1'b0}, // R8
        '{32'h00000000, 32'd0,        32'd0, 32'h00000000, 1'b0}, // R3 wrap
        '{32'h0FFFFFFF, 32'd0,        32'd0, 32'h0FFFFFFC, 1'b1}, // R7
        '{32'h01200009, 32'h40,       32'd0, 32'h10000000, 1'b0}  // R3 funct 9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_addr;
    logic [31:0] link_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    pcu_next_addr u0 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
        .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic present(input logic a, input logic [31:0] i,
                           input logic [31:0] s, input logic [31:0] t);
        @(negedge clk);
        adv = a; instr = i; rs_val = s; rt_val = t;
        #1;
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] prev;
        // R1: reset state
        present(1'b1, 32'h08004E23, 0, 0);
        tick; tick;
        check("R1 reset value", pc, 32'd0);
        rst_n = 1'b1;

        prev = 32'd0;
        for (int k = 0; k < NV; k++) begin
            present(1'b1, VECS[k].instr, VECS[k].rs, VECS[k].rt);
            check("R9 link_we", {31'd0, link_we}, {31'd0, VECS[k].lwe_exp});
            check("R9 link_data", link_data, prev + 32'd4);
            check("R9 link_addr", {27'd0, link_addr}, 32'd31);
            tick;
            check($sformatf("R3-R8 vector %0d pc", k), pc, VECS[k].pc_exp);
            prev = VECS[k].pc_exp;
        end

        // R2: no advance holds the PC, and a call does not request a link
        present(1'b0, 32'h0C004E20, 0, 0);
        check("R9 no link without adv", {31'd0, link_we}, 32'd0);
        tick;
        check("R2 hold on jal", pc, prev);
        present(1'b0, 32'h01200008, 32'h1234, 0);
        tick;
        check("R2 hold on jr", pc, prev);

        // R1: reset beats advance mid-run
        present(1'b1, 32'h08004E23, 0, 0);
        rst_n = 1'b0;
        tick;
        check("R1 reset over adv", pc, 32'd0);
        rst_n = 1'b1;

        // R5 example from the address 80012 again
        present(1'b1, 32'h08004E23, 0, 0);
        tick;
        present(1'b1, 32'h14000002, 32'hA, 32'hB);
        tick;
        check("R5 bne 80012 -> 80024", pc, 32'd80024);

        // R6 example: field 20000 from region 0
        present(1'b1, 32'h08004E20, 0, 0);
        tick;
        check("R6 j 20000 -> 80000", pc, 32'd80000);
        adv = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule